// File: doc/BRIEF.md
# Instruction Predecode-on-Fill Unit

This unit sits on the refill path of an instruction cache. Each refill beat brings one cache line of four 32-bit instructions and the address the line was fetched from. In one pass the unit labels every instruction with a 4-bit class tag. It finds the direct branches in the line and works out their target addresses. It takes an initial guess for each branch from the hint bit in its encoding. From these results it forms the stored successor line index and the 2-bit prediction counters that go into the cache alongside the line. Because this work is done once, at fill time, the fetch path later reads the successor and the counters directly and never has to decode a branch.

The decode is combinational and its result is captured in output registers. A two-state machine tracks the output beat. In `ST_IDLE` no result is being presented. A refill beat (`fill_valid` high) moves the machine to `ST_EMIT` (transition IDLE->EMIT). It stays in `ST_EMIT` while beats keep arriving back to back (EMIT->EMIT). It returns to `ST_IDLE` on the first cycle with no beat (EMIT->IDLE). If there is no beat while idle, it stays in `ST_IDLE` (IDLE->IDLE). `out_valid` is high exactly while the machine is in `ST_EMIT`, so the result of a beat appears one cycle after the beat.

Top module: `pdf_fill_predecode`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle in which `fill_valid` was sampled high, and low after a cycle in which it was sampled low. Beats on consecutive cycles therefore keep `out_valid` high.
- R2: Instruction slot i is `fill_data[32*i+31:32*i]`. Its opcode is bits [31:26]. Bits [2:0] of tag i give the class, decided in this order: an all-zero word is 0 (none); opcode 0x04 is 1 (conditional branch); 0x05 is 2 (unconditional branch); 0x06 is 3 (call); 0x07 is 4 (return); opcode bits [5:4]=10 is 5 (load/store); bits [5:4]=01 is 6 (ALU); anything else is 7 (other). Tag i is `out_tags[4*i+3:4*i]`.
- R3: Tag bit 3 marks a branch that is predicted taken. It is set for a conditional branch whose hint bit 25 is 1, and for every unconditional branch and call. It is clear for all other slots, including returns and conditional branches with hint 0.
- R4: For a conditional branch, unconditional branch or call in slot i, `out_tgt[32*i+31:32*i]` equals the line base + 4*i + (bits [18:0] sign-extended and shifted left by 2), computed modulo 2^32. The line base is `fill_addr` with bits [3:0] cleared. For every other slot this field is zero.
- R5: If any slot is predicted taken, `out_succ` is bits [31:4] of the target of the lowest-numbered predicted-taken slot.
- R6: If no slot is predicted taken, `out_succ` is `fill_addr[31:4]` + 1, and it wraps to zero after the last line.
- R7: Prediction pair p, `out_pred[2*p+1:2*p]`, covers slots 2p and 2p+1. It is 2'b10 if either of those slots is predicted taken, and 2'b01 otherwise.
- R8: In a cycle with `fill_valid` low, the `fill_addr` and `fill_data` inputs have no effect. The registered tags, targets, successor and counters keep their values.
- R9: While reset is held, `out_valid`, `out_tags`, `out_tgt`, `out_succ` and `out_pred` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | A refill beat is present this cycle |
| fill_addr | input | 32 | Fetch address of the line (low 4 bits ignored) |
| fill_data | input | 128 | Four instructions, slot 0 in the low word |
| out_valid | output | 1 | Registered result of the previous beat is presented |
| out_tags | output | 16 | Four 4-bit predecode tags |
| out_tgt | output | 128 | Per-slot branch target address, zero for non-branches |
| out_succ | output | 28 | Initial successor line index |
| out_pred | output | 4 | Two initial 2-bit prediction counters |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, four slots per line and a 19-bit displacement. These values let it reach the top line of the address space, where the sequential successor wraps to line zero. They also let it use the most negative displacement from a low address, so the target wraps below zero. The directed lines place predicted-taken branches in every pair position and put two of them in one line to test the program-order priority. They mix hint-0 conditionals and returns with taken branches, send beats back to back, and change the inputs between beats to show that they are ignored.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_COND   = 3'd1,
        CLS_UNCOND = 3'd2,
        CLS_CALL   = 3'd3,
        CLS_RET    = 3'd4,
        CLS_LDST   = 3'd5,
        CLS_ALU    = 3'd6,
        CLS_OTHER  = 3'd7
    } instr_class_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } fill_state_e;

    localparam logic [5:0] OP_COND   = 6'h04;
    localparam logic [5:0] OP_UNCOND = 6'h05;
    localparam logic [5:0] OP_CALL   = 6'h06;
    localparam logic [5:0] OP_RET    = 6'h07;
    localparam int         HINT_BIT  = 25;

    function automatic instr_class_e classify(input logic [31:0] word);
        logic [5:0] op;
        op = word[31:26];
        if (word == 32'h0)           return CLS_NONE;
        else if (op == OP_COND)      return CLS_COND;
        else if (op == OP_UNCOND)    return CLS_UNCOND;
        else if (op == OP_CALL)      return CLS_CALL;
        else if (op == OP_RET)       return CLS_RET;
        else if (op[5:4] == 2'b10)   return CLS_LDST;
        else if (op[5:4] == 2'b01)   return CLS_ALU;
        else                         return CLS_OTHER;
    endfunction

endpackage

// File: rtl/pdf_slot_decode.sv
module pdf_slot_decode
    import pdf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 19,
    parameter int SLOT   = 0
) (
    input  logic [ADDR_W-1:0] line_base,
    input  logic [31:0]       instr,
    output logic [3:0]        tag,
    output logic              taken,
    output logic [ADDR_W-1:0] target
);

    localparam int EXT_W = ADDR_W - DISP_W - 2;

    instr_class_e        cls;
    logic                is_direct;
    logic [ADDR_W-1:0]   slot_pc;
    logic [ADDR_W-1:0]   offset;

    always_comb begin
        cls       = classify(instr);
        is_direct = (cls == CLS_COND) || (cls == CLS_UNCOND) || (cls == CLS_CALL);
        taken     = ((cls == CLS_COND) && instr[HINT_BIT]) ||
                    (cls == CLS_UNCOND) || (cls == CLS_CALL);
        slot_pc   = line_base + ADDR_W'(SLOT * 4);
        offset    = {{EXT_W{instr[DISP_W-1]}}, instr[DISP_W-1:0], 2'b00};
        target    = is_direct ? (slot_pc + offset) : '0;
        tag       = {taken, cls};
    end

endmodule

// File: rtl/pdf_succ_select.sv
module pdf_succ_select #(
    parameter int ADDR_W = 32,
    parameter int SLOTS  = 4,
    parameter int OFF_W  = 4
) (
    input  logic [SLOTS-1:0]        taken,
    input  logic [SLOTS*ADDR_W-1:0] targets,
    input  logic [ADDR_W-OFF_W-1:0] line_idx,
    output logic [ADDR_W-OFF_W-1:0] succ
);

    localparam int SUCC_W = ADDR_W - OFF_W;

    always_comb begin
        succ = line_idx + SUCC_W'(1);
        // scan from the last slot down so the earliest taken slot wins
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (taken[i]) begin
                succ = targets[i*ADDR_W + OFF_W +: SUCC_W];
            end
        end
    end

endmodule

// File: rtl/pdf_pred_init.sv
module pdf_pred_init #(
    parameter int SLOTS = 4
) (
    input  logic [SLOTS-1:0] taken,
    output logic [SLOTS-1:0] pred
);

    localparam int NPAIR = SLOTS / 2;
    localparam logic [1:0] WEAK_TAKEN     = 2'b10;
    localparam logic [1:0] WEAK_NOT_TAKEN = 2'b01;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign pred[2*p +: 2] = (taken[2*p] || taken[2*p+1]) ? WEAK_TAKEN : WEAK_NOT_TAKEN;
    end

endmodule

// File: rtl/pdf_fill_predecode.sv
module pdf_fill_predecode
    import pdf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SLOTS  = 4,
    parameter int DISP_W = 19
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       fill_valid,
    input  logic [ADDR_W-1:0]                          fill_addr,
    input  logic [SLOTS*32-1:0]                        fill_data,
    output logic                                       out_valid,
    output logic [SLOTS*4-1:0]                         out_tags,
    output logic [SLOTS*ADDR_W-1:0]                    out_tgt,
    output logic [ADDR_W-$clog2(SLOTS*4)-1:0]          out_succ,
    output logic [SLOTS-1:0]                           out_pred
);

    localparam int OFF_W  = $clog2(SLOTS * 4);
    localparam int SUCC_W = ADDR_W - OFF_W;

    fill_state_e state_q, state_d;

    logic [ADDR_W-1:0]        line_base;
    logic [SLOTS*4-1:0]       tags_c;
    logic [SLOTS*ADDR_W-1:0]  tgt_c;
    logic [SLOTS-1:0]         taken_c;
    logic [SUCC_W-1:0]        succ_c;
    logic [SLOTS-1:0]         pred_c;

    assign line_base = {fill_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        pdf_slot_decode #(
            .ADDR_W (ADDR_W),
            .DISP_W (DISP_W),
            .SLOT   (i)
        ) u_dec (
            .line_base (line_base),
            .instr     (fill_data[32*i +: 32]),
            .tag       (tags_c[4*i +: 4]),
            .taken     (taken_c[i]),
            .target    (tgt_c[ADDR_W*i +: ADDR_W])
        );
    end

    pdf_succ_select #(
        .ADDR_W (ADDR_W),
        .SLOTS  (SLOTS),
        .OFF_W  (OFF_W)
    ) u_succ (
        .taken    (taken_c),
        .targets  (tgt_c),
        .line_idx (fill_addr[ADDR_W-1:OFF_W]),
        .succ     (succ_c)
    );

    pdf_pred_init #(
        .SLOTS (SLOTS)
    ) u_pred (
        .taken (taken_c),
        .pred  (pred_c)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = fill_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = fill_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // output registers, loaded only on a refill beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_tags <= '0;
            out_tgt  <= '0;
            out_succ <= '0;
            out_pred <= '0;
        end else if (fill_valid) begin
            out_tags <= tags_c;
            out_tgt  <= tgt_c;
            out_succ <= succ_c;
            out_pred <= pred_c;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

endmodule

// File: rtl/pdf_fill_predecode_chk.sv
module pdf_fill_predecode_chk #(
    parameter int ADDR_W = 32,
    parameter int SLOTS  = 4
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                fill_valid,
    input logic [ADDR_W-1:0]                   fill_addr,
    input logic [SLOTS*32-1:0]                 fill_data,
    input logic                                out_valid,
    input logic [SLOTS*4-1:0]                  out_tags,
    input logic [SLOTS*ADDR_W-1:0]             out_tgt,
    input logic [ADDR_W-$clog2(SLOTS*4)-1:0]   out_succ,
    input logic [SLOTS-1:0]                    out_pred
);

    localparam int OFF_W  = $clog2(SLOTS * 4);
    localparam int SUCC_W = ADDR_W - OFF_W;
    localparam int NPAIR  = SLOTS / 2;

    logic any_taken;
    always_comb begin
        any_taken = 1'b0;
        for (int i = 0; i < SLOTS; i++) any_taken |= out_tags[4*i+3];
    end

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> out_valid);

    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |=> !out_valid);

    assert_seq_succ_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid ##1 !any_taken |-> out_succ == SUCC_W'($past(fill_addr[ADDR_W-1:OFF_W]) + SUCC_W'(1)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |=> ($stable(out_tags) && $stable(out_tgt) &&
                         $stable(out_succ) && $stable(out_pred)));

    for (genvar i = 0; i < SLOTS; i++) begin : g_tag
        assert_taken_is_branch_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_tags[4*i+3] |-> (out_tags[4*i +: 3] inside {3'd1, 3'd2, 3'd3}));
        assert_tgt_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !(out_tags[4*i +: 3] inside {3'd1, 3'd2, 3'd3}) |-> out_tgt[ADDR_W*i +: ADDR_W] == '0);
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assert_pair_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_pred[2*p +: 2] ==
                ((out_tags[8*p+3] || out_tags[8*p+7]) ? 2'b10 : 2'b01)));
    end

endmodule

bind pdf_fill_predecode pdf_fill_predecode_chk #(
    .ADDR_W (ADDR_W),
    .SLOTS  (SLOTS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_valid (fill_valid),
    .fill_addr  (fill_addr),
    .fill_data  (fill_data),
    .out_valid  (out_valid),
    .out_tags   (out_tags),
    .out_tgt    (out_tgt),
    .out_succ   (out_succ),
    .out_pred   (out_pred)
);

// File: tb/pdf_fill_predecode_bench.sv
`timescale 1ns/1ps
module pdf_fill_predecode_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fill_valid = 1'b0;
    logic [31:0]  fill_addr = '0;
    logic [127:0] fill_data = '0;
    logic         out_valid;
    logic [15:0]  out_tags;
    logic [127:0] out_tgt;
    logic [27:0]  out_succ;
    logic [3:0]   out_pred;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0]  exp_tags;
    logic [127:0] exp_tgt;
    logic [27:0]  exp_succ;
    logic [3:0]   exp_pred;

    always #2.5 clk = ~clk;

    pdf_fill_predecode u_pdf_fill_predecode (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_valid (fill_valid),
        .fill_addr  (fill_addr),
        .fill_data  (fill_data),
        .out_valid  (out_valid),
        .out_tags   (out_tags),
        .out_tgt    (out_tgt),
        .out_succ   (out_succ),
        .out_pred   (out_pred)
    );

    // instruction builders
    function automatic logic [31:0] br(input logic [5:0] op, input logic hint, input int disp);
        logic [31:0] d;
        d = disp;
        return {op, hint, 6'b0, d[18:0]};
    endfunction
    localparam logic [31:0] I_LDST  = {6'h21, 26'h0000123};
    localparam logic [31:0] I_ALU   = {6'h12, 26'h0000055};
    localparam logic [31:0] I_OTHER = {6'h3F, 26'h0000001};
    localparam logic [31:0] I_NOP   = 32'h0;
    localparam logic [31:0] I_RET   = {6'h07, 26'h0};

    // expected results from the requirements
    task automatic model(input logic [31:0] a, input logic [127:0] d);
        logic [27:0] li;
        logic        found;
        li = a[31:4];
        found = 1'b0;
        exp_succ = li + 28'd1;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] w;
            logic [2:0]  c;
            logic        tk;
            logic [31:0] pc, off, t;
            w = d[32*i +: 32];
            if (w == 0)                 c = 3'd0;
            else if (w[31:26] == 6'h04) c = 3'd1;
            else if (w[31:26] == 6'h05) c = 3'd2;
            else if (w[31:26] == 6'h06) c = 3'd3;
            else if (w[31:26] == 6'h07) c = 3'd4;
            else if (w[31:30] == 2'b10) c = 3'd5;
            else if (w[31:30] == 2'b01) c = 3'd6;
            else                        c = 3'd7;
            tk  = (c == 3'd1 && w[25]) || c == 3'd2 || c == 3'd3;
            pc  = {li, 4'b0} + 32'(4 * i);
            off = {{11{w[18]}}, w[18:0], 2'b00};
            t   = (c >= 3'd1 && c <= 3'd3) ? pc + off : 32'h0;
            exp_tags[4*i +: 4] = {tk, c};
            exp_tgt[32*i +: 32] = t;
            if (tk && !found) begin
                found = 1'b1;
                exp_succ = t[31:4];
            end
        end
        for (int p = 0; p < 2; p++)
            exp_pred[2*p +: 2] = (exp_tags[8*p+3] || exp_tags[8*p+7]) ? 2'b10 : 2'b01;
    endtask

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R1 valid"}, 128'(out_valid), 128'd1);
        chk({tag, " R2/R3 tags"}, 128'(out_tags), 128'(exp_tags));
        chk({tag, " R4 targets"}, out_tgt, exp_tgt);
        chk({tag, " R5/R6 succ"}, 128'(out_succ), 128'(exp_succ));
        chk({tag, " R7 pred"}, 128'(out_pred), 128'(exp_pred));
    endtask

    task automatic beat(input string tag, input logic [31:0] a, input logic [127:0] d);
        @(negedge clk);
        fill_addr = a;
        fill_data = d;
        fill_valid = 1'b1;
        model(a, d);
        @(negedge clk);
        fill_valid = 1'b0;
        check_all(tag);
    endtask

    task automatic t_reset_r9();
        chk("R9 valid", 128'(out_valid), 0);
        chk("R9 tags", 128'(out_tags), 0);
        chk("R9 tgt", out_tgt, 0);
        chk("R9 succ", 128'(out_succ), 0);
        chk("R9 pred", 128'(out_pred), 0);
    endtask

    task automatic t_no_branch_r2();
        beat("nobranch R2 R6", 32'h0000_2000, {I_OTHER, I_NOP, I_ALU, I_LDST});
    endtask

    task automatic t_forward_cond_r5();
        beat("fwdcond R3 R5", 32'h0000_1000, {I_ALU, br(6'h04, 1'b1, 32'h40), I_LDST, I_ALU});
    endtask

    task automatic t_hint0_call_r3();
        beat("hint0call R3 R4", 32'h0001_0004,
             {br(6'h06, 1'b0, -300), I_RET, I_ALU, br(6'h04, 1'b0, 32'h10)});
    endtask

    task automatic t_two_taken_r5();
        beat("twotaken R5", 32'h0000_4000,
             {br(6'h04, 1'b1, 32'h8), I_ALU, br(6'h05, 1'b0, 32'h1000), I_NOP});
    endtask

    task automatic t_ret_only_r3();
        beat("retonly R3 R6", 32'h0000_3000, {I_ALU, I_ALU, I_RET, I_RET});
    endtask

    task automatic t_wrap_r6();
        beat("wrap R6", 32'hFFFF_FFF7, {I_LDST, I_LDST, I_ALU, I_OTHER});
        chk("wrap R6 succ zero", 128'(out_succ), 0);
    endtask

    task automatic t_neg_wrap_r4();
        beat("negwrap R4", 32'h0000_0010, {I_NOP, I_NOP, I_NOP, br(6'h05, 1'b0, 32'h0004_0000)});
        chk("negwrap R4 slot0", 128'(out_tgt[31:0]), 128'(32'hFFF0_0010));
    endtask

    task automatic t_back_to_back_r1();
        logic [127:0] da, db;
        da = {I_ALU, I_ALU, I_ALU, br(6'h06, 1'b0, 32'h20)};
        db = {br(6'h04, 1'b1, -4), I_ALU, I_ALU, I_ALU};
        @(negedge clk);
        fill_addr = 32'h0000_8000; fill_data = da; fill_valid = 1'b1;
        @(negedge clk);
        model(32'h0000_8000, da);
        check_all("b2b first R1");
        fill_addr = 32'h0000_9000; fill_data = db;
        @(negedge clk);
        fill_valid = 1'b0;
        model(32'h0000_9000, db);
        check_all("b2b second R1");
        @(negedge clk);
        chk("b2b R1 valid drops", 128'(out_valid), 0);
    endtask

    task automatic t_hold_r8();
        beat("hold base", 32'h0000_5000, {I_LDST, br(6'h05, 1'b0, 32'h30), I_ALU, I_ALU});
        fill_addr = 32'hABCD_0000;
        fill_data = {4{br(6'h04, 1'b1, 32'h7)}};
        @(negedge clk);
        chk("R8 valid low", 128'(out_valid), 0);
        chk("R8 tags held", 128'(out_tags), 128'(exp_tags));
        chk("R8 tgt held", out_tgt, exp_tgt);
        chk("R8 succ held", 128'(out_succ), 128'(exp_succ));
        chk("R8 pred held", 128'(out_pred), 128'(exp_pred));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r9();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 128'(out_valid), 0);
        t_no_branch_r2();
        t_forward_cond_r5();
        t_hint0_call_r3();
        t_two_taken_r5();
        t_ret_only_r3();
        t_wrap_r6();
        t_neg_wrap_r4();
        t_back_to_back_r1();
        t_hold_r8();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule